// File: doc/BRIEF.md
# 8b/10b Running-Disparity Encoder

This block turns one byte per clock into one 10-bit DC-balanced line code group. A flag that comes with the byte marks it as a control (K) character. The byte is split into a 5-bit low part (EDCBA, value x) and a 3-bit high part (HGF, value y). The two parts go through a 6-bit sub-block encoder and a 4-bit sub-block encoder in parallel. A third path supplies the alternate 4-bit code used by certain D.x.7 characters.

A single running-disparity (RD) bit decides which column of the code table is used. The 6-bit sub-block is chosen by the current RD. The 4-bit sub-block is chosen by the disparity that remains after the 6-bit sub-block. After every character the RD bit is updated and fed back.

Control bytes that are not one of the twelve legal K characters raise a flag. Such a byte is still encoded, as the data character with the same byte value. The output is registered, so a code group appears one cycle after its byte.

Top module: `dcb_enc_top`

## Requirements
- R1: `out_code[9:4]` holds the 6-bit sub-block abcdei, with bit a at bit 9, and it is derived from `in_byte[4:0]`. `out_code[3:0]` holds the 4-bit sub-block fghj, with bit f at bit 3, and it is derived from `in_byte[7:5]`.
- R2: The 6-bit sub-block follows the standard 5b/6b table. For example, D0 is 100111, D7 is 111000 and D31 is 101011 in the negative column. The positive-column entry is the bitwise complement for unbalanced entries and for x=7. It is the same value for the other balanced entries.
- R3: Every code group has four, five or six ones. With RD negative before the character the group never has four ones. With RD positive before the character it never has six ones.
- R4: A code group with five ones leaves RD unchanged, and any other code group flips RD. The 4-bit sub-block column is selected by RD after the 6-bit sub-block. The data 4-bit codes in the negative column are 1011, 1001, 0101, 1100, 1101, 1010, 0110 and 1110 for y = 0 to 7. The positive column is the complement for y = 0, 3, 4 and 7.
- R5: For y=7 data, the alternate 4-bit code is used instead of the primary code. It is 0111 with intermediate RD negative, for x in {17, 18, 20}. It is 1000 with intermediate RD positive, for x in {11, 13, 14}.
- R6: With `in_ctrl` high, the legal characters are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. K28 uses the 6-bit sub-block 001111 (negative) or 110000 (positive). Legal K characters use the control 4-bit codes: negative column 1011, 0110, 1010, 1100, 1101, 0101, 1001 and 0111 for y = 0 to 7, with the positive column the complement.
- R7: `out_bad_ctrl` is 1 for a control byte that is not legal, and the byte is then encoded as the data character with the same value. It is 0 for legal K characters and for all data bytes.
- R8: A byte taken with `in_valid` high appears on `out_code` one clock later, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next clock. It leaves `out_code`, `out_bad_ctrl` and `rd_pos` unchanged.
- R9: While `rst_n` is low, `out_valid`, `out_code` and `out_bad_ctrl` are 0 and `rd_pos` is 0, which means negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is presented this cycle |
| in_ctrl | input | 1 | The byte is a control character |
| in_byte | input | 8 | Byte to encode, HGF in bits 7..5, EDCBA in bits 4..0 |
| out_valid | output | 1 | `out_code` holds a new code group |
| out_code | output | 10 | Code group, abcdei in bits 9..4, fghj in bits 3..0 |
| out_bad_ctrl | output | 1 | The last control byte was not a legal K character |
| rd_pos | output | 1 | Running disparity after the last code group, 1 = positive |

## Verification
The assertions watch the following on every cycle:
- every emitted group has a weight of 4 to 6 ones;
- a negative-RD start never yields a negative group, and a positive-RD start never yields a positive group;
- RD flips exactly when a group is unbalanced;
- idle cycles hold the registers;
- data and K28 bytes never raise the invalid-control flag.

Whether each individual code word matches the table can only be shown by the bench's scenarios. These are:
- a sweep of all 256 data bytes and all 256 control bytes, in each RD state;
- a targeted check of the alternate D.x.7 cases;
- random mixed streams with idle gaps.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int X_W  = 5;
   localparam int Y_W  = 3;
   localparam int S6_W = 6;
   localparam int S4_W = 4;
   localparam int BYTE_W = X_W + Y_W;
   localparam int CODE_W = S6_W + S4_W;

   localparam logic [X_W-1:0]  K28_X     = 5'd28;
   localparam logic [Y_W-1:0]  Y_ALT     = 3'd7;
   localparam logic [S6_W-1:0] K28_NEG6  = 6'b001111;
   localparam logic [S4_W-1:0] ALT_NEG4  = 4'b0111;

   typedef struct packed {
      logic [S6_W-1:0] neg;
      logic [S6_W-1:0] pos;
      logic            unbal;
   } sub6_t;

   typedef struct packed {
      logic [S4_W-1:0] neg;
      logic [S4_W-1:0] pos;
      logic            unbal;
   } sub4_t;
endpackage

// File: rtl/dcb_sub6_enc.sv
module dcb_sub6_enc
   import dcb_pkg::*;
(
   input  logic [X_W-1:0] x_i,
   input  logic           k28_i,
   output sub6_t          s6_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [S6_W-1:0] base;
   logic            unbal;
   logic            flip_bal;

   always_comb begin
      unique case (x_i)
         5'd0:  base = 6'b100111;
         5'd1:  base = 6'b011101;
         5'd2:  base = 6'b101101;
         5'd3:  base = 6'b110001;
         5'd4:  base = 6'b110101;
         5'd5:  base = 6'b101001;
         5'd6:  base = 6'b011001;
         5'd7:  base = 6'b111000;
         5'd8:  base = 6'b111001;
         5'd9:  base = 6'b100101;
         5'd10: base = 6'b010101;
         5'd11: base = 6'b110100;
         5'd12: base = 6'b001101;
         5'd13: base = 6'b101100;
         5'd14: base = 6'b011100;
         5'd15: base = 6'b010111;
         5'd16: base = 6'b011011;
         5'd17: base = 6'b100011;
         5'd18: base = 6'b010011;
         5'd19: base = 6'b110010;
         5'd20: base = 6'b001011;
         5'd21: base = 6'b101010;
         5'd22: base = 6'b011010;
         5'd23: base = 6'b111010;
         5'd24: base = 6'b110011;
         5'd25: base = 6'b100110;
         5'd26: base = 6'b010110;
         5'd27: base = 6'b110110;
         5'd28: base = 6'b001110;
         5'd29: base = 6'b101110;
         5'd30: base = 6'b011110;
         default: base = 6'b101011;
      endcase
   end

   always_comb begin
      s6_o.neg = k28_i ? K28_NEG6 : base;
      unbal    = ($countones(s6_o.neg) != 3);
      flip_bal = (x_i == 5'd7) && !k28_i;
      s6_o.pos = (unbal || flip_bal) ? ~s6_o.neg : s6_o.neg;
      s6_o.unbal = unbal;
   end

   always_comb begin
      if (!$isunknown(x_i) && !$isunknown(k28_i)) begin
         AST_S6_NEG_WEIGHT: assert ($countones(s6_o.neg) == 3 || $countones(s6_o.neg) == 4); // R2
      end
   end
endmodule

// File: rtl/dcb_sub4_enc.sv
module dcb_sub4_enc
   import dcb_pkg::*;
(
   input  logic [Y_W-1:0] y_i,
   input  logic           kmode_i,
   output sub4_t          s4_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [S4_W-1:0] d_neg;
   logic [S4_W-1:0] k_neg;

   always_comb begin
      unique case (y_i)
         3'd0: begin d_neg = 4'b1011; k_neg = 4'b1011; end
         3'd1: begin d_neg = 4'b1001; k_neg = 4'b0110; end
         3'd2: begin d_neg = 4'b0101; k_neg = 4'b1010; end
         3'd3: begin d_neg = 4'b1100; k_neg = 4'b1100; end
         3'd4: begin d_neg = 4'b1101; k_neg = 4'b1101; end
         3'd5: begin d_neg = 4'b1010; k_neg = 4'b0101; end
         3'd6: begin d_neg = 4'b0110; k_neg = 4'b1001; end
         default: begin d_neg = 4'b1110; k_neg = 4'b0111; end
      endcase
   end

   always_comb begin
      s4_o.neg   = kmode_i ? k_neg : d_neg;
      s4_o.unbal = ($countones(s4_o.neg) != 2);
      if (kmode_i || s4_o.unbal || (y_i == 3'd3)) s4_o.pos = ~s4_o.neg;
      else                                        s4_o.pos = s4_o.neg;
   end

   always_comb begin
      if (!$isunknown(y_i) && !$isunknown(kmode_i)) begin
         AST_S4_NEG_WEIGHT: assert ($countones(s4_o.neg) == 2 || $countones(s4_o.neg) == 3); // R4
      end
   end
endmodule

// File: rtl/dcb_alt4_sel.sv
module dcb_alt4_sel
   import dcb_pkg::*;
(
   input  logic [X_W-1:0] x_i,
   input  logic [Y_W-1:0] y_i,
   input  logic           legal_k_i,
   output logic           use_neg_o,
   output logic           use_pos_o,
   output sub4_t          alt_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic is_y7;
   logic hit_neg;
   logic hit_pos;

   always_comb begin
      is_y7   = (y_i == Y_ALT);
      hit_neg = (x_i == 5'd17) || (x_i == 5'd18) || (x_i == 5'd20);
      hit_pos = (x_i == 5'd11) || (x_i == 5'd13) || (x_i == 5'd14);
      use_neg_o = is_y7 && (legal_k_i || hit_neg);
      use_pos_o = is_y7 && (legal_k_i || hit_pos);
      alt_o.neg   = ALT_NEG4;
      alt_o.pos   = ~ALT_NEG4;
      alt_o.unbal = 1'b1;
   end
endmodule

// File: rtl/dcb_kchk.sv
module dcb_kchk
   import dcb_pkg::*;
(
   input  logic [X_W-1:0] x_i,
   input  logic [Y_W-1:0] y_i,
   input  logic           ctrl_i,
   output logic           legal_o,
   output logic           bad_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic y7_set;

   always_comb begin
      y7_set  = (x_i == 5'd23) || (x_i == 5'd27) || (x_i == 5'd29) || (x_i == 5'd30);
      legal_o = ctrl_i && ((x_i == K28_X) || ((y_i == Y_ALT) && y7_set));
      bad_o   = ctrl_i && !legal_o;
   end
endmodule

// File: rtl/dcb_rd_ctrl.sv
module dcb_rd_ctrl
   import dcb_pkg::*;
(
   input  logic            rd_i,
   input  sub6_t           s6_i,
   input  sub4_t           s4_i,
   input  logic            alt_use_neg_i,
   input  logic            alt_use_pos_i,
   input  sub4_t           alt_i,
   output logic [S6_W-1:0] six_o,
   output logic [S4_W-1:0] four_o,
   output logic            rd_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic mid_rd;
   logic take_alt;
   logic four_unbal;

   always_comb begin
      six_o    = rd_i ? s6_i.pos : s6_i.neg;
      mid_rd   = rd_i ^ s6_i.unbal;
      take_alt = mid_rd ? alt_use_pos_i : alt_use_neg_i;
      if (take_alt) begin
         four_o     = mid_rd ? alt_i.pos : alt_i.neg;
         four_unbal = alt_i.unbal;
      end else begin
         four_o     = mid_rd ? s4_i.pos : s4_i.neg;
         four_unbal = s4_i.unbal;
      end
      rd_o = mid_rd ^ four_unbal;
   end
endmodule

// File: rtl/dcb_enc_top.sv
module dcb_enc_top
   import dcb_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int OUT_W        = 10,
   parameter bit RESET_RD_POS = 1'b0,
   parameter bit A_AT_MSB     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic [DATA_W-1:0] in_byte,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_code,
   output logic              out_bad_ctrl,
   output logic              rd_pos
);
   timeunit 1ns;
   timeprecision 1ps;

   if (DATA_W != BYTE_W) begin : g_bad_data_w
      $error("dcb_enc_top: DATA_W must equal %0d", BYTE_W);
   end
   if (OUT_W != CODE_W) begin : g_bad_out_w
      $error("dcb_enc_top: OUT_W must equal %0d", CODE_W);
   end

   logic [X_W-1:0]  x_part;
   logic [Y_W-1:0]  y_part;
   logic            k_legal;
   logic            k_bad;
   sub6_t           s6;
   sub4_t           s4;
   sub4_t           alt4;
   logic            alt_neg;
   logic            alt_pos;
   logic [S6_W-1:0] six;
   logic [S4_W-1:0] four;
   logic            rd_next;
   logic [OUT_W-1:0] nxt_code;
   logic [OUT_W-1:0] msb_code;

   assign x_part   = in_byte[X_W-1:0];
   assign y_part   = in_byte[DATA_W-1:X_W];
   assign msb_code = {six, four};

   dcb_kchk u_kchk (
      .x_i     (x_part),
      .y_i     (y_part),
      .ctrl_i  (in_ctrl),
      .legal_o (k_legal),
      .bad_o   (k_bad)
   );

   dcb_sub6_enc u_sub6 (
      .x_i   (x_part),
      .k28_i (k_legal && (x_part == K28_X)),
      .s6_o  (s6)
   );

   dcb_sub4_enc u_sub4 (
      .y_i     (y_part),
      .kmode_i (k_legal),
      .s4_o    (s4)
   );

   dcb_alt4_sel u_alt4 (
      .x_i       (x_part),
      .y_i       (y_part),
      .legal_k_i (k_legal),
      .use_neg_o (alt_neg),
      .use_pos_o (alt_pos),
      .alt_o     (alt4)
   );

   dcb_rd_ctrl u_rdc (
      .rd_i          (rd_pos),
      .s6_i          (s6),
      .s4_i          (s4),
      .alt_use_neg_i (alt_neg),
      .alt_use_pos_i (alt_pos),
      .alt_i         (alt4),
      .six_o         (six),
      .four_o        (four),
      .rd_o          (rd_next)
   );

   if (A_AT_MSB) begin : g_a_msb
      assign nxt_code = msb_code;
   end else begin : g_a_lsb
      for (genvar gi = 0; gi < OUT_W; gi++) begin : g_rev
         assign nxt_code[gi] = msb_code[OUT_W-1-gi];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_code     <= '0;
         out_bad_ctrl <= 1'b0;
         rd_pos       <= RESET_RD_POS;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_code     <= nxt_code;
            out_bad_ctrl <= k_bad;
            rd_pos       <= rd_next;
         end
      end
   end

   AST_DISP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_code) >= 4 && $countones(out_code) <= 6)); // R3
   AST_COLUMN_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(rd_pos)) |-> ($countones(out_code) >= 5)); // R3
   AST_COLUMN_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(rd_pos)) |-> ($countones(out_code) <= 5)); // R3
   AST_RD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((rd_pos != $past(rd_pos)) == ($countones(out_code) != 5))); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(rd_pos) && $stable(out_code) && $stable(out_bad_ctrl))); // R8
   AST_DATA_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ctrl) |=> !out_bad_ctrl); // R7
   AST_K28_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ctrl && in_byte[X_W-1:0] == K28_X) |=> !out_bad_ctrl); // R6
endmodule

// File: tb/dcb_enc_top_tb_top.sv
module dcb_enc_top_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ctrl = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid;
   logic [9:0] out_code;
   logic       out_bad_ctrl;
   logic       rd_pos;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   typedef struct {
      logic       vld;
      logic [9:0] code;
      logic       bad;
      logic       rd;
      int         due;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   logic       m_rd   = 1'b0;
   logic [9:0] m_code = '0;
   logic       m_bad  = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dcb_enc_top dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ctrl      (in_ctrl),
      .in_byte      (in_byte),
      .out_valid    (out_valid),
      .out_code     (out_code),
      .out_bad_ctrl (out_bad_ctrl),
      .rd_pos       (rd_pos)
   );

   function automatic logic [5:0] ref6(input logic [4:0] x);
      logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                            6'b110101, 6'b101001, 6'b011001, 6'b111000,
                            6'b111001, 6'b100101, 6'b010101, 6'b110100,
                            6'b001101, 6'b101100, 6'b011100, 6'b010111,
                            6'b011011, 6'b100011, 6'b010011, 6'b110010,
                            6'b001011, 6'b101010, 6'b011010, 6'b111010,
                            6'b110011, 6'b100110, 6'b010110, 6'b110110,
                            6'b001110, 6'b101110, 6'b011110, 6'b101011};
      return t[x];
   endfunction

   function automatic logic [3:0] ref4d(input logic [2:0] y);
      logic [3:0] t [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                           4'b1101, 4'b1010, 4'b0110, 4'b1110};
      return t[y];
   endfunction

   function automatic logic [3:0] ref4k(input logic [2:0] y);
      logic [3:0] t [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100,
                           4'b1101, 4'b0101, 4'b1001, 4'b0111};
      return t[y];
   endfunction

   // Reference model: R1 R2 R4 R5 R6 R7
   task automatic model(input logic [7:0] b, input logic k);
      logic [4:0] x;
      logic [2:0] y;
      logic legal, mid, alt;
      logic [5:0] s;
      logic [3:0] f;
      x = b[4:0];
      y = b[7:5];
      legal = k && (x == 5'd28 || (y == 3'd7 &&
              (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30)));
      s = (legal && x == 5'd28) ? 6'b001111 : ref6(x);
      if (m_rd && ($countones(s) != 3 || (x == 5'd7 && !(legal && x == 5'd28)))) s = ~s;
      mid = m_rd ^ ($countones(s) != 3);
      if (legal) begin
         f = ref4k(y);
         if (mid) f = ~f;
      end else if (y == 3'd7) begin
         alt = mid ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                   : (x == 5'd17 || x == 5'd18 || x == 5'd20);
         f = alt ? 4'b0111 : 4'b1110;
         if (mid) f = ~f;
      end else begin
         f = ref4d(y);
         if (mid && ($countones(f) != 2 || y == 3'd3)) f = ~f;
      end
      m_rd   = mid ^ ($countones(f) != 2);
      m_code = {s, f};
      m_bad  = k && !legal;
   endtask

   task automatic send(input logic [7:0] b, input logic k, input logic v, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = v;
      in_byte  = b;
      in_ctrl  = k;
      if (v) model(b, k);
      e.vld = v;
      e.code = m_code;
      e.bad = m_bad;
      e.rd = m_rd;
      e.due = cyc + 1;
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic to_rd(input logic target);
      if (m_rd != target) send(8'h03, 1'b0, 1'b1, "R4 rd-steer");
   endtask

   task automatic fail_line(input string tag, input string what, input logic [9:0] act, input logic [9:0] expv);
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
   endtask

   // Monitor / scoreboard
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            e = sb_q.pop_front();
            checks++;
            if (out_valid !== e.vld) fail_line({e.tag, " R8"}, "out_valid", {9'd0, out_valid}, {9'd0, e.vld});
            else if (out_code !== e.code) fail_line(e.tag, "out_code", out_code, e.code);
            else if (out_bad_ctrl !== e.bad) fail_line({e.tag, " R7"}, "out_bad_ctrl", {9'd0, out_bad_ctrl}, {9'd0, e.bad});
            else if (rd_pos !== e.rd) fail_line({e.tag, " R4"}, "rd_pos", {9'd0, rd_pos}, {9'd0, e.rd});
            if (e.vld) begin
               checks++;
               if ($countones(out_code) < 4 || $countones(out_code) > 6)
                  fail_line("R3", "weight", out_code, 10'd0);
            end
         end
      end
   end

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_code !== 10'd0 || out_bad_ctrl !== 1'b0 || rd_pos !== 1'b0)
         fail_line("R9", "reset state", {out_valid, out_bad_ctrl, rd_pos, out_code[6:0]}, 10'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R4: first character after reset uses the negative column
      send(8'h00, 1'b0, 1'b1, "R1 R2 D0.0 from reset");
      send(8'h00, 1'b0, 1'b1, "R2 D0.0 repeat");

      // Full data sweep in both RD states (R1 R2 R4 R5)
      for (int rdv = 0; rdv < 2; rdv++) begin
         for (int b = 0; b < 256; b++) begin
            to_rd(rdv[0]);
            send(b[7:0], 1'b0, 1'b1, (b[7:5] == 3'd7) ? "R5 data y7" : "R2 R4 data");
         end
      end

      // Full control sweep in both RD states (R6 R7)
      for (int rdv = 0; rdv < 2; rdv++) begin
         for (int b = 0; b < 256; b++) begin
            to_rd(rdv[0]);
            send(b[7:0], 1'b1, 1'b1, "R6 R7 control");
         end
      end

      // R5 targeted: alternate-code characters under each RD
      to_rd(1'b0);
      send({3'd7, 5'd17}, 1'b0, 1'b1, "R5 D17.7 rd-");
      to_rd(1'b1);
      send({3'd7, 5'd11}, 1'b0, 1'b1, "R5 D11.7 rd+");
      to_rd(1'b0);
      send({3'd7, 5'd11}, 1'b0, 1'b1, "R5 D11.7 rd- primary");

      // R8: idle cycles hold outputs
      send(8'hBC, 1'b1, 1'b1, "R6 K28.5");
      send(8'h00, 1'b0, 1'b0, "R8 idle");
      send(8'hFF, 1'b1, 1'b0, "R8 idle with junk");
      send(8'h4A, 1'b0, 1'b1, "R8 resume");

      // Random mixed stream with gaps (R3 R4 R8)
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] rb;
         logic rk;
         logic rv;
         rb = 8'($urandom);
         rk = ($urandom % 5) == 0;
         rv = ($urandom % 8) != 0;
         if (rk && ($urandom % 2) == 0) rb[4:0] = 5'd28;
         send(rb, rk, rv, "R3 R4 random");
      end

      send(8'h00, 1'b0, 1'b0, "R8 tail idle");
      repeat (4) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule